// File: doc/BRIEF.md
# Eight-Port Serial Controller Host Register Interface

This block sits between a 16-bit host bus and the register files of eight identical serial ports. The host starts an access with a one-cycle request that carries a cycle type, a byte offset, a direction and write data. The block captures the request, holds it for a number of wait states set by the cycle type, and then raises a one-cycle acknowledge. In that cycle it pulses a read or write strobe to the addressed target and returns read data.

Each port owns a 16-byte window. The windows are stacked from offset 0x00, so the eighth port starts at 0x70. Within a window the registers sit on odd byte offsets. Only the low data byte carries register content, and the upper byte of every read is all ones. Two further cycle types are served in the same way. An interrupt-select cycle returns the vector supplied by the ports. An identification read returns a byte from an external identification store that the block addresses.

Top module: `mport_host_if`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ack_o` is 0 and every strobe output (`port_rd_o`, `port_wr_o`, `irq_ack_o`, `id_rd_o`) is 0.
- R2: A request with `space_i` = 0 (I/O space) is acknowledged 2 cycles after the clock edge that accepts it, which is one wait state.
- R3: A request with `space_i` = 1 (interrupt select) is acknowledged 3 cycles after acceptance, which is two wait states. A read returns {8'hFF, `irq_vec_i`} and pulses `irq_ack_o` in the acknowledge cycle.
- R4: A request with `space_i` = 2 (identification) is acknowledged 1 cycle after acceptance, which is zero wait states. A read returns {8'hFF, `id_data_i`}, pulses `id_rd_o`, and presents the request offset on `id_addr_o`.
- R5: An I/O access to an odd offset below 0x80 selects port `addr_i[6:4]` and register `addr_i[3:1]`. A read pulses only that bit of `port_rd_o` and returns {8'hFF, byte p of `port_rdata_i`}, where byte p is bits [8p+7:8p].
- R6: Bits 15..8 of `rdata_o` are all ones on every acknowledged read, whatever the cycle type.
- R7: An I/O write to a valid register pulses only the selected bit of `port_wr_o`, for exactly one cycle: the acknowledge cycle. In that cycle `port_reg_o` is the register select and `port_wdata_o` equals `wdata_i[7:0]`.
- R8: An I/O access to an even offset or to an offset of 0x80 or above is still acknowledged after one wait state. It raises no strobe, and a read returns 16'hFFFF.
- R9: A write with `space_i` of 1, 2 or 3, and a read with `space_i` = 3, are acknowledged and raise no strobe. Code 3 uses the I/O latency and reads 16'hFFFF.
- R10: A request that arrives while an access is in progress is ignored. The captured offset, direction and data are kept, and exactly one acknowledge results.
- R11: Strobes appear only in a cycle in which `ack_o` is high, and at most one bit of `port_rd_o` or `port_wr_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, sampled while idle |
| space_i | input | 2 | Cycle type: 0 I/O, 1 interrupt select, 2 identification, 3 reserved |
| addr_i | input | 8 | Byte offset |
| wr_i | input | 1 | 1 for write, 0 for read |
| wdata_i | input | 16 | Write data; only bits 7..0 are forwarded |
| ack_o | output | 1 | One-cycle acknowledge |
| rdata_o | output | 16 | Read data, valid with `ack_o` |
| port_rd_o | output | 8 | Per-port read strobes |
| port_wr_o | output | 8 | Per-port write strobes |
| port_reg_o | output | 3 | Register select within the port |
| port_wdata_o | output | 8 | Write byte to the ports |
| port_rdata_i | input | 64 | Read bytes from the ports, byte p for port p |
| irq_ack_o | output | 1 | Interrupt-select strobe |
| irq_vec_i | input | 8 | Interrupt vector |
| id_rd_o | output | 1 | Identification read strobe |
| id_addr_o | output | 8 | Identification offset |
| id_data_i | input | 8 | Identification byte |

## Verification
The assertions assume that reset starts every run, so the wait counter never holds a value above its captured limit. They also assume that the port and identification inputs are settled in the acknowledge cycle. The stimulus raises requests only at the falling edge, one at a time, and waits one cycle after each acknowledge before the next request. The only exception is the deliberate overlapping request for R10. The port stubs answer combinationally from their own storage, so read data is stable in the acknowledge cycle. The stimulus sweeps every byte offset for both directions, which covers the even offsets, the out-of-window offsets and each port boundary.

// File: rtl/mport_pkg.sv
package mport_pkg;
    typedef enum logic [1:0] {
        SP_IO     = 2'd0,
        SP_INTSEL = 2'd1,
        SP_ID     = 2'd2,
        SP_RSVD   = 2'd3
    } space_e;
endpackage

// File: rtl/mport_decode.sv
module mport_decode
    import mport_pkg::*;
#(
    parameter int NPORT      = 8,
    parameter int PORT_BYTES = 16,
    parameter int ADDR_W     = 8,
    localparam int PSEL_W    = $clog2(NPORT),
    localparam int RSEL_W    = $clog2(PORT_BYTES) - 1
) (
    input  space_e              space,
    input  logic [ADDR_W-1:0]   addr,
    output logic                io_hit,
    output logic [PSEL_W-1:0]   psel,
    output logic [RSEL_W-1:0]   rsel
);
    localparam int MAP_BYTES = NPORT * PORT_BYTES;

    logic in_window;

    always_comb begin
        in_window = (int'(addr) < MAP_BYTES);
        io_hit    = (space == SP_IO) && in_window && addr[0];
        psel      = addr[RSEL_W+1 +: PSEL_W];
        rsel      = addr[RSEL_W:1];
    end
endmodule

// File: rtl/mport_wait.sv
module mport_wait #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] ws_i,
    output logic             busy,
    output logic             ack
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] ws;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.cnt  = '0;
                st_d.ws   = ws_i;
            end
        end else if (st_q.cnt == st_q.ws) begin
            st_d.busy = 1'b0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign ack  = st_q.busy && (st_q.cnt == st_q.ws);

    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.cnt <= st_q.ws));
    a_r10_ws_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !ack) |=> $stable(st_q.ws));
    a_r10_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
endmodule

// File: rtl/mport_strobe.sv
module mport_strobe
    import mport_pkg::*;
#(
    parameter int NPORT   = 8,
    localparam int PSEL_W = $clog2(NPORT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              wr,
    input  space_e            space,
    input  logic              io_hit,
    input  logic [PSEL_W-1:0] psel,
    output logic [NPORT-1:0]  port_rd,
    output logic [NPORT-1:0]  port_wr,
    output logic              irq_ack,
    output logic              id_rd
);
    genvar p;
    generate
        for (p = 0; p < NPORT; p++) begin : g_port
            always_comb begin
                port_rd[p] = fire && io_hit && !wr && (int'(psel) == p);
                port_wr[p] = fire && io_hit &&  wr && (int'(psel) == p);
            end
        end
    endgenerate

    always_comb begin
        irq_ack = fire && !wr && (space == SP_INTSEL);
        id_rd   = fire && !wr && (space == SP_ID);
    end

    a_r11_rd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_rd));
    a_r11_wr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_wr));
    a_r7_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr != '0) |=> (port_wr == '0));
    a_r8_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !io_hit) |-> (port_rd == '0 && port_wr == '0));
endmodule

// File: rtl/mport_host_if.sv
module mport_host_if
    import mport_pkg::*;
#(
    parameter int NPORT      = 8,
    parameter int PORT_BYTES = 16,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int BYTE_W     = 8,
    parameter int WS_IO      = 1,
    parameter int WS_INTSEL  = 2,
    parameter int WS_ID      = 0,
    localparam int PSEL_W    = $clog2(NPORT),
    localparam int RSEL_W    = $clog2(PORT_BYTES) - 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_i,
    input  logic [1:0]              space_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    wr_i,
    input  logic [DATA_W-1:0]       wdata_i,
    output logic                    ack_o,
    output logic [DATA_W-1:0]       rdata_o,
    output logic [NPORT-1:0]        port_rd_o,
    output logic [NPORT-1:0]        port_wr_o,
    output logic [RSEL_W-1:0]       port_reg_o,
    output logic [BYTE_W-1:0]       port_wdata_o,
    input  logic [NPORT*BYTE_W-1:0] port_rdata_i,
    output logic                    irq_ack_o,
    input  logic [BYTE_W-1:0]       irq_vec_i,
    output logic                    id_rd_o,
    output logic [ADDR_W-1:0]       id_addr_o,
    input  logic [BYTE_W-1:0]       id_data_i
);
    localparam int HI_W   = DATA_W - BYTE_W;
    localparam int MAX_A  = (WS_IO > WS_INTSEL) ? WS_IO : WS_INTSEL;
    localparam int MAX_WS = (MAX_A > WS_ID) ? MAX_A : WS_ID;
    localparam int CNT_W  = (MAX_WS < 1) ? 1 : $clog2(MAX_WS + 1);

    typedef struct packed {
        space_e              space;
        logic [ADDR_W-1:0]   addr;
        logic                wr;
        logic [DATA_W-1:0]   wdata;
    } hreq_t;

    hreq_t             req_d, req_q;
    logic              busy, ack, accept;
    logic [CNT_W-1:0]  ws_sel;
    logic              io_hit;
    logic [PSEL_W-1:0] psel;
    logic [RSEL_W-1:0] rsel;

    always_comb begin
        accept = req_i && !busy;
        req_d  = req_q;
        if (accept) begin
            req_d.space = space_e'(space_i);
            req_d.addr  = addr_i;
            req_d.wr    = wr_i;
            req_d.wdata = wdata_i;
        end
        case (space_e'(space_i))
            SP_INTSEL: ws_sel = CNT_W'(WS_INTSEL);
            SP_ID:     ws_sel = CNT_W'(WS_ID);
            default:   ws_sel = CNT_W'(WS_IO);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    mport_wait #(.CNT_W(CNT_W)) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .ws_i  (ws_sel),
        .busy  (busy),
        .ack   (ack)
    );

    mport_decode #(.NPORT(NPORT), .PORT_BYTES(PORT_BYTES), .ADDR_W(ADDR_W)) u_dec (
        .space  (req_q.space),
        .addr   (req_q.addr),
        .io_hit (io_hit),
        .psel   (psel),
        .rsel   (rsel)
    );

    mport_strobe #(.NPORT(NPORT)) u_stb (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (ack),
        .wr      (req_q.wr),
        .space   (req_q.space),
        .io_hit  (io_hit),
        .psel    (psel),
        .port_rd (port_rd_o),
        .port_wr (port_wr_o),
        .irq_ack (irq_ack_o),
        .id_rd   (id_rd_o)
    );

    always_comb begin
        rdata_o = '1;
        case (req_q.space)
            SP_IO:
                if (io_hit)
                    rdata_o = {{HI_W{1'b1}}, port_rdata_i[psel*BYTE_W +: BYTE_W]};
            SP_INTSEL: rdata_o = {{HI_W{1'b1}}, irq_vec_i};
            SP_ID:     rdata_o = {{HI_W{1'b1}}, id_data_i};
            default:   rdata_o = '1;
        endcase
    end

    assign ack_o        = ack;
    assign port_reg_o   = rsel;
    assign port_wdata_o = req_q.wdata[BYTE_W-1:0];
    assign id_addr_o    = req_q.addr;

    a_r6_upper_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && !req_q.wr) |-> (rdata_o[DATA_W-1:BYTE_W] == {HI_W{1'b1}}));
    a_r11_strobe_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ((port_rd_o != '0) || (port_wr_o != '0) || irq_ack_o || id_rd_o) |-> ack_o);
    a_r10_req_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ack) |=> $stable(req_q));
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ack_o && port_wr_o == '0 && port_rd_o == '0));
endmodule

// File: tb/mport_host_if_tb.sv
module mport_host_if_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [1:0]  space_i = 2'd0;
    logic [7:0]  addr_i = 8'd0;
    logic        wr_i = 1'b0;
    logic [15:0] wdata_i = 16'd0;
    logic        ack_o;
    logic [15:0] rdata_o;
    logic [7:0]  port_rd_o, port_wr_o;
    logic [2:0]  port_reg_o;
    logic [7:0]  port_wdata_o;
    logic [63:0] port_rdata_i;
    logic        irq_ack_o;
    logic [7:0]  irq_vec_i = 8'hA7;
    logic        id_rd_o;
    logic [7:0]  id_addr_o;
    logic [7:0]  id_data_i;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic done = 1'b0;

    logic [7:0] stub [8][8];
    logic [7:0] mdl  [8][8];

    always #5 clk = ~clk;

    mport_host_if u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .space_i(space_i),
        .addr_i(addr_i), .wr_i(wr_i), .wdata_i(wdata_i), .ack_o(ack_o),
        .rdata_o(rdata_o), .port_rd_o(port_rd_o), .port_wr_o(port_wr_o),
        .port_reg_o(port_reg_o), .port_wdata_o(port_wdata_o),
        .port_rdata_i(port_rdata_i), .irq_ack_o(irq_ack_o),
        .irq_vec_i(irq_vec_i), .id_rd_o(id_rd_o), .id_addr_o(id_addr_o),
        .id_data_i(id_data_i)
    );

    assign id_data_i = ~id_addr_o;

    always_comb begin
        for (int p = 0; p < 8; p++) port_rdata_i[p*8 +: 8] = stub[p][port_reg_o];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < 8; p++)
                for (int r = 0; r < 8; r++) stub[p][r] <= 8'(p*8 + r);
        end else begin
            for (int p = 0; p < 8; p++)
                if (port_wr_o[p]) stub[p][port_reg_o] <= port_wdata_o;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Runs one access; returns latency in cycles and the values seen with ack.
    task automatic access(input logic [1:0] sp, input logic [7:0] a, input logic w,
                          input logic [15:0] d, output int lat, output logic [15:0] rd,
                          output logic [7:0] prd, output logic [7:0] pwr, output logic [2:0] preg,
                          output logic [7:0] pwd, output logic irq, output logic idr,
                          output logic [7:0] ida, output int early);
        @(negedge clk);
        req_i = 1'b1; space_i = sp; addr_i = a; wr_i = w; wdata_i = d;
        @(negedge clk);
        req_i = 1'b0;
        lat = 1; early = 0;
        while (!ack_o && lat < 10) begin
            if (port_rd_o != 0 || port_wr_o != 0 || irq_ack_o || id_rd_o) early++;
            @(negedge clk);
            lat++;
        end
        rd = rdata_o; prd = port_rd_o; pwr = port_wr_o; preg = port_reg_o;
        pwd = port_wdata_o; irq = irq_ack_o; idr = id_rd_o; ida = id_addr_o;
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int lat, early;
        logic [15:0] rd;
        logic [7:0] prd, pwr, pwd, ida;
        logic [2:0] preg;
        logic irq, idr;
        logic valid;
        int p, r;

        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++) mdl[i][j] = 8'(i*8 + j);

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!ack_o && port_rd_o == 0 && port_wr_o == 0 && !irq_ack_o && !id_rd_o,
            "R1 reset quiet", {31'd0, ack_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ack_o && port_rd_o == 0 && port_wr_o == 0, "R1 after reset", {31'd0, ack_o}, 0);

        // R2 R5 R7 R8: write sweep over every offset
        for (int a = 0; a < 256; a++) begin
            valid = (a < 128) && (a % 2 == 1);
            p = (a >> 4) & 7; r = (a >> 1) & 7;
            access(2'd0, 8'(a), 1'b1, {8'hC3, 8'(a) ^ 8'h5A}, lat, rd, prd, pwr, preg, pwd, irq, idr, ida, early);
            chk(lat == 2, "R2 io write latency", lat, 2);
            chk(early == 0, "R11 no strobe before ack", early, 0);
            if (valid) begin
                chk(pwr == 8'(1 << p) && prd == 0, "R7 write strobe", {24'd0, pwr}, 1 << p);
                chk(preg == 3'(r) && pwd == (8'(a) ^ 8'h5A), "R7 write reg/data", {preg, pwd}, {3'(r), 8'(a) ^ 8'h5A});
                mdl[p][r] = 8'(a) ^ 8'h5A;
            end else begin
                chk(pwr == 0 && prd == 0 && !irq && !idr, "R8 no strobe on miss", {pwr, prd}, 0);
            end
            @(negedge clk);
            chk(!ack_o && port_wr_o == 0, "R7 single pulse", {port_wr_o, 7'd0, ack_o}, 0);
        end

        // R2 R5 R6 R8: read sweep
        for (int a = 0; a < 256; a++) begin
            valid = (a < 128) && (a % 2 == 1);
            p = (a >> 4) & 7; r = (a >> 1) & 7;
            access(2'd0, 8'(a), 1'b0, 16'h0, lat, rd, prd, pwr, preg, pwd, irq, idr, ida, early);
            chk(lat == 2, "R2 io read latency", lat, 2);
            chk(rd[15:8] == 8'hFF, "R6 upper ones", rd, 16'hFF00);
            if (valid) begin
                chk(prd == 8'(1 << p) && pwr == 0, "R5 read strobe", {24'd0, prd}, 1 << p);
                chk(rd == {8'hFF, mdl[p][r]}, "R5 read data", rd, {8'hFF, mdl[p][r]});
            end else begin
                chk(rd == 16'hFFFF && prd == 0, "R8 miss reads ones", rd, 16'hFFFF);
            end
        end

        // R3: interrupt select
        access(2'd1, 8'h00, 1'b0, 16'h0, lat, rd, prd, pwr, preg, pwd, irq, idr, ida, early);
        chk(lat == 3, "R3 intsel latency", lat, 3);
        chk(rd == 16'hFFA7 && irq && !idr && prd == 0, "R3 intsel data", rd, 16'hFFA7);
        irq_vec_i = 8'h3C;
        access(2'd1, 8'h40, 1'b0, 16'h0, lat, rd, prd, pwr, preg, pwd, irq, idr, ida, early);
        chk(rd == 16'hFF3C && irq, "R3 intsel vector 2", rd, 16'hFF3C);

        // R4: identification reads
        for (int a = 0; a < 256; a += 37) begin
            access(2'd2, 8'(a), 1'b0, 16'h0, lat, rd, prd, pwr, preg, pwd, irq, idr, ida, early);
            chk(lat == 1, "R4 id latency", lat, 1);
            chk(idr && !irq && ida == 8'(a) && rd == {8'hFF, ~8'(a)}, "R4 id data", rd, {8'hFF, ~8'(a)});
            chk(rd[15:8] == 8'hFF, "R6 id upper ones", rd, 16'hFF00);
        end

        // R9: writes outside I/O space and reserved code
        for (int s = 1; s < 4; s++) begin
            access(2'(s), 8'h11, 1'b1, 16'h00EE, lat, rd, prd, pwr, preg, pwd, irq, idr, ida, early);
            chk(lat == ((s == 1) ? 3 : (s == 2) ? 1 : 2), "R9 latency", lat, s);
            chk(pwr == 0 && prd == 0 && !irq && !idr, "R9 no strobe", {pwr, prd}, 0);
        end
        access(2'd3, 8'h11, 1'b0, 16'h0, lat, rd, prd, pwr, preg, pwd, irq, idr, ida, early);
        chk(lat == 2 && rd == 16'hFFFF && prd == 0, "R9 reserved read", rd, 16'hFFFF);
        access(2'd0, 8'h11, 1'b0, 16'h0, lat, rd, prd, pwr, preg, pwd, irq, idr, ida, early);
        chk(rd == {8'hFF, mdl[1][0]}, "R9 register untouched", rd, {8'hFF, mdl[1][0]});

        // R10: request held and changed while busy
        begin
            int acks = 0;
            int wrs = 0;
            @(negedge clk);
            req_i = 1'b1; space_i = 2'd0; addr_i = 8'h13; wr_i = 1'b1; wdata_i = 16'h0077;
            @(negedge clk);
            addr_i = 8'h25; wdata_i = 16'h0099;
            if (ack_o) acks++;
            @(negedge clk);
            if (ack_o) begin acks++; if (port_wr_o == 8'h02 && port_reg_o == 3'd1 && port_wdata_o == 8'h77) wrs++; end
            @(negedge clk);
            req_i = 1'b0;
            for (int k = 0; k < 5; k++) begin
                if (ack_o) acks++;
                @(negedge clk);
            end
            chk(acks == 1, "R10 single ack", acks, 1);
            chk(wrs == 1, "R10 first request kept", wrs, 1);
            mdl[1][1] = 8'h77;
            access(2'd0, 8'h25, 1'b0, 16'h0, lat, rd, prd, pwr, preg, pwd, irq, idr, ida, early);
            chk(rd == {8'hFF, mdl[2][2]}, "R10 later request ignored", rd, {8'hFF, mdl[2][2]});
            access(2'd0, 8'h13, 1'b0, 16'h0, lat, rd, prd, pwr, preg, pwd, irq, idr, ida, early);
            chk(rd == 16'hFF77, "R10 captured write landed", rd, 16'hFF77);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule